// File: doc/BRIEF.md
# Asynchronous Static RAM Word Controller

This block sits between a clocked client and an external 16-bit asynchronous static RAM with 19 address lines. The client hands over one word access at a time through a valid/ready handshake, with an address, write data, a two-bit lane mask and a direction flag. The controller turns each access into pin activity that meets the RAM's nanosecond limits. It latches the address and lane mask and keeps them steady for the whole access. It opens the chip selects and the lane strobes. On a read it lowers output enable for a counted window. On a write it lowers write enable for a counted pulse, placed between a lead-in cycle and a closing cycle.

All nanosecond limits become cycle counts during elaboration. Two parameters drive this: the clock period, and a grade selector that picks the 70 ns or the 100 ns set of limits. Between accesses the RAM is held in standby, with both selects and both strobes inactive. The controller drives the shared data lines only while write enable is low, so the bus is never driven from both ends when the direction changes. Read data comes back with a one-cycle valid pulse, and every lane that was not requested reads as zero.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and whenever no access is in progress, the pins sit in standby: ce1 low-active select high, ce2 select low, output enable high, write enable high, both lane strobes high, and data drivers off. Ready is high and read-valid is low.
- R2: Each window length is ceil(limit_ns / CLK_PERIOD_NS), with a floor of one cycle. With SLOW_GRADE = 0 and a 10 ns clock, the read window is 7 cycles and the write pulse is 6 cycles.
- R3: A read holds the part selected, output enable low and write enable high for exactly the read window. The address pins carry the accepted address and do not change until the access ends.
- R4: Read data appears the cycle after the read window ends, with read-valid high for that one cycle. Mask bit 0 selects data bits 7:0 and mask bit 1 selects bits 15:8. A lane whose mask bit is 0 returns zero.
- R5: For the whole access, the lower strobe is low exactly when mask bit 0 is set, and the upper strobe is low exactly when mask bit 1 is set.
- R6: A write takes one lead-in cycle (selected, strobes set, output enable and write enable high), then write enable low for exactly the write pulse, then one closing cycle (still selected, write enable high). After that the part returns to standby.
- R7: The data drivers are on only while write enable is low, and never while output enable is low.
- R8: While write enable is low, the data pins carry the accepted write data. A lane with its mask bit clear keeps its former memory contents.
- R9: Ready is low from acceptance until the access, including its closing cycle, has finished. A request that arrives meanwhile is not taken, and the address pins keep the current address.
- R10: Read-valid rises only after a read and never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data, unrequested lanes zero |
| mem_addr | output | 19 | RAM address pins |
| mem_ce1_n | output | 1 | Low-active chip select |
| mem_ce2 | output | 1 | High-active chip select |
| mem_oe_n | output | 1 | Output enable, low-active |
| mem_we_n | output | 1 | Write enable, low-active |
| mem_ub_n | output | 1 | Upper lane strobe, low-active |
| mem_lb_n | output | 1 | Lower lane strobe, low-active |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | 16 | Data from the RAM |

## Verification
Two events can land in the same cycle: the return of read data and the acceptance of the next request. The bench provokes this by holding a write request valid for the whole of a read. It then checks that the address does not move before the read ends, and that read-valid and ready are both high in one cycle. The cycle after that must be a write lead-in, with the drivers off, output enable high and the new address on the pins. The read data returned in that shared cycle is compared against the bench's own copy of memory.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_WLEAD  = 3'd2,
    PH_WPULSE = 3'd3,
    PH_WCLOSE = 3'd4
  } phase_t;

  // nanosecond limit -> whole clock cycles, never below one
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned pick(bit slow, int unsigned fast_ns, int unsigned slow_ns);
    return slow ? slow_ns : fast_ns;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // read window: cycle time, address access and output-enable access
  function automatic int unsigned read_cycles(int unsigned period, bit slow);
    int unsigned r;
    r = ns_to_cycles(pick(slow, 70, 100), period);
    r = max2(r, ns_to_cycles(pick(slow, 70, 100), period));
    r = max2(r, ns_to_cycles(pick(slow, 35, 50), period));
    return r;
  endfunction

  // write-enable pulse; the lead-in cycle counts toward select, address and
  // strobe setup, lead-in plus closing cycle toward the full write cycle
  function automatic int unsigned pulse_cycles(int unsigned period, bit slow);
    int unsigned p;
    p = ns_to_cycles(pick(slow, 55, 80), period);
    p = max2(p, ns_to_cycles(pick(slow, 30, 40), period));
    p = max2(p, ns_to_cycles(pick(slow, 65, 80), period) - 1);
    p = max2(p, ns_to_cycles(pick(slow, 60, 80), period) - 1);
    if (ns_to_cycles(pick(slow, 70, 100), period) > 2)
      p = max2(p, ns_to_cycles(pick(slow, 70, 100), period) - 2);
    return (p == 0) ? 1 : p;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 7,
  parameter int unsigned WE_CYC = 6,
  parameter int unsigned CNT_W  = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  output logic   req_ready,
  output phase_t state_q,
  output phase_t state_d,
  output logic   accept,
  output logic   rd_last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             we_last;

  assign req_ready = (state_q == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_last   = (state_q == PH_READ)   && (cnt_q == CNT_W'(1));
  assign we_last   = (state_q == PH_WPULSE) && (cnt_q == CNT_W'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      PH_IDLE: if (accept) begin
        state_d = req_write ? PH_WLEAD : PH_READ;
        cnt_d   = CNT_W'(RD_CYC);
      end
      PH_READ: begin
        cnt_d = cnt_q - CNT_W'(1);
        if (rd_last) state_d = PH_IDLE;
      end
      PH_WLEAD: begin
        state_d = PH_WPULSE;
        cnt_d   = CNT_W'(WE_CYC);
      end
      PH_WPULSE: begin
        cnt_d = cnt_q - CNT_W'(1);
        if (we_last) state_d = PH_WCLOSE;
      end
      PH_WCLOSE: state_d = PH_IDLE;
      default:   state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // a counted window never runs with an empty counter
  assert_cnt_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_READ || state_q == PH_WPULSE) |-> (cnt_q != '0));

  // the closing cycle always follows a write pulse
  assert_close_after_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_WCLOSE) |-> ($past(state_q) == PH_WPULSE));

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            state_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [LANES-1:0]  lane_q,
  output logic [LANES-1:0]  strb_n,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_dq_oe
);

  logic             busy_d;
  logic [LANES-1:0] mask_d;

  assign busy_d = (state_d != PH_IDLE);
  assign mask_d = accept ? req_mask : lane_q;

  // every pin comes straight from a flop so the strobes cannot glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      lane_q     <= '0;
      mem_ce1_n  <= 1'b1;
      mem_ce2    <= 1'b0;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
        lane_q     <= req_mask;
      end
      mem_ce1_n <= !busy_d;
      mem_ce2   <= busy_d;
      mem_oe_n  <= !(state_d == PH_READ);
      mem_we_n  <= !(state_d == PH_WPULSE);
      mem_dq_oe <= (state_d == PH_WPULSE);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_strb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strb_n[g] <= 1'b1;
      else        strb_n[g] <= !(busy_d && mask_d[g]);
    end
  end

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_drive_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  assert_we_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2));

  assert_write_data_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_dq_out));

endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_last,
  input  logic [LANES-1:0]  lane_q,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_last;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data[g*8 +: 8] <= '0;
      else if (rd_last) rd_data[g*8 +: 8] <= lane_q[g] ? mem_dq_in[g*8 +: 8] : 8'h00;
    end

    assert_unrequested_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !lane_q[g]) |-> (rd_data[g*8 +: 8] == 8'h00));
  end

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter bit          SLOW_GRADE    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned LANES   = 2;
  localparam int unsigned RD_CYC  = read_cycles(CLK_PERIOD_NS, SLOW_GRADE);
  localparam int unsigned WE_CYC  = pulse_cycles(CLK_PERIOD_NS, SLOW_GRADE);
  localparam int unsigned MAX_CYC = max2(RD_CYC, WE_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  phase_t           state_q, state_d;
  logic             accept, rd_last;
  logic [LANES-1:0] lane_q, strb_n;

  sram_ctrl_fsm #(.RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk, .rst_n, .req_valid, .req_write, .req_ready,
    .state_q, .state_d, .accept, .rd_last
  );

  sram_ctrl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_pins (
    .clk, .rst_n, .state_d, .accept, .req_addr, .req_wdata, .req_mask,
    .mem_addr, .mem_dq_out, .lane_q, .strb_n,
    .mem_ce1_n, .mem_ce2, .mem_oe_n, .mem_we_n, .mem_dq_oe
  );

  sram_ctrl_rdcap #(.DATA_W(DATA_W), .LANES(LANES)) u_rdcap (
    .clk, .rst_n, .rd_last, .lane_q, .mem_dq_in, .rd_valid, .rd_data
  );

  assign mem_lb_n = strb_n[0];
  assign mem_ub_n = strb_n[1];

  // length of the current write-enable low run, for the pulse check
  logic [CNT_W-1:0] chk_we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chk_we_run <= '0;
    else if (!mem_we_n) chk_we_run <= chk_we_run + CNT_W'(1);
    else                chk_we_run <= '0;
  end

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && !$past(mem_we_n)) |-> (chk_we_run == CNT_W'(WE_CYC)));

  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_ub_n && mem_lb_n && mem_we_n && !mem_dq_oe));

  assert_addr_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

  assert_valid_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (!$past(mem_oe_n)));

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

  localparam int CLK_NS = 10;

  function automatic int up_div(int ns);
    int q;
    q = ns / CLK_NS;
    if (q * CLK_NS < ns) q = q + 1;
    if (q < 1) q = 1;
    return q;
  endfunction

  function automatic int bigger(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // R2: fast-grade windows restated from the limits
  localparam int RD_EXP = up_div(70);
  localparam int WE_EXP = bigger(bigger(up_div(55), up_div(30)),
                                 bigger(bigger(up_div(65) - 1, up_div(60) - 1), up_div(70) - 2));

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data;
  logic [18:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .req_mask, .rd_valid, .rd_data, .mem_addr, .mem_ce1_n, .mem_ce2, .mem_oe_n,
    .mem_we_n, .mem_ub_n, .mem_lb_n, .mem_dq_out, .mem_dq_oe, .mem_dq_in
  );

  // ---------------- RAM model (256 words, low address bits) ----------------
  function automatic logic [15:0] seed_word(int i);
    return {8'(i) ^ 8'h3C, ~8'(i)};
  endfunction

  logic [15:0] sram  [256];
  logic [15:0] shadow[256];
  logic        sel;
  assign sel = !mem_ce1_n && mem_ce2;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) sram[i] <= seed_word(i);
    end else if (sel && !mem_we_n) begin
      if (!mem_lb_n) sram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) sram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  always_comb begin
    mem_dq_in = 16'hEEEE;  // floating lanes read as junk
    if (sel && !mem_oe_n && mem_we_n) begin
      if (!mem_lb_n) mem_dq_in[7:0]  = sram[mem_addr[7:0]][7:0];
      if (!mem_ub_n) mem_dq_in[15:8] = sram[mem_addr[7:0]][15:8];
    end
  end

  // ---------------- checking ----------------
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pins: {ce1_n, ce2, oe_n, we_n, ub_n, lb_n, dq_oe, ready}
  function automatic logic [7:0] pins();
    return {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready};
  endfunction
  localparam logic [7:0] STANDBY = 8'b1011_1101;
  function automatic logic [7:0] busy_pins(logic oe_n, logic we_n, logic [1:0] m, logic dqoe);
    return {1'b0, 1'b1, oe_n, we_n, ~m[1], ~m[0], dqoe, 1'b0};
  endfunction

  // R7 on every cycle: drivers never fight the RAM
  always @(negedge clk) begin
    if (rst_n && !done)
      check(!(mem_dq_oe && (!mem_oe_n || mem_we_n)), "R7", {mem_dq_oe, mem_oe_n, mem_we_n}, 3'b010);
  end

  function automatic logic [18:0] full_addr(logic [7:0] a);
    return {11'h501, a};
  endfunction

  function automatic logic [15:0] lane_mask(logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic access(input logic wr, input logic [1:0] m, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    check(req_ready == 1'b1, "R9", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_mask = m; req_addr = full_addr(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      for (int i = 1; i <= RD_EXP; i++) begin
        check(pins() == busy_pins(1'b0, 1'b1, m, 1'b0), "R3/R5", pins(), busy_pins(1'b0, 1'b1, m, 1'b0));
        check(mem_addr == full_addr(a) && !rd_valid, "R3", {rd_valid, mem_addr}, {1'b0, full_addr(a)});
        @(negedge clk);
      end
      check(rd_valid == 1'b1, "R4", rd_valid, 1);
      check(rd_data == (shadow[a] & lane_mask(m)), "R4", rd_data, shadow[a] & lane_mask(m));
      check(pins() == STANDBY, "R1", pins(), STANDBY);
      @(negedge clk);
      check(rd_valid == 1'b0, "R10", rd_valid, 0);
    end else begin
      check(pins() == busy_pins(1'b1, 1'b1, m, 1'b0), "R6 lead-in", pins(), busy_pins(1'b1, 1'b1, m, 1'b0));
      @(negedge clk);
      for (int i = 1; i <= WE_EXP; i++) begin
        check(pins() == busy_pins(1'b1, 1'b0, m, 1'b1), "R6/R5 pulse", pins(), busy_pins(1'b1, 1'b0, m, 1'b1));
        check(mem_dq_out == d && mem_addr == full_addr(a), "R8", mem_dq_out, d);
        @(negedge clk);
      end
      check(pins() == busy_pins(1'b1, 1'b1, m, 1'b0), "R6 close", pins(), busy_pins(1'b1, 1'b1, m, 1'b0));
      @(negedge clk);
      check(pins() == STANDBY, "R1 R9", pins(), STANDBY);
      shadow[a] = (shadow[a] & ~lane_mask(m)) | (d & lane_mask(m));
    end
  endtask

  // {write, mask, addr, data}
  localparam int NVEC = 10;
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b1, 2'b11, 8'h10, 16'h1234},
    {1'b0, 2'b11, 8'h10, 16'h0000},
    {1'b1, 2'b01, 8'h10, 16'hABCD},
    {1'b0, 2'b11, 8'h10, 16'h0000},
    {1'b1, 2'b10, 8'h20, 16'h5AA5},
    {1'b0, 2'b01, 8'h20, 16'h0000},
    {1'b0, 2'b10, 8'h20, 16'h0000},
    {1'b1, 2'b11, 8'hFF, 16'hFFFF},
    {1'b0, 2'b11, 8'hFF, 16'h0000},
    {1'b0, 2'b11, 8'h00, 16'h0000}
  };

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = seed_word(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pins() == STANDBY && !rd_valid, "R1", {rd_valid, pins()}, {1'b0, STANDBY});
    rst_n = 1'b1;
    @(negedge clk);
    check(pins() == STANDBY && !rd_valid, "R1", {rd_valid, pins()}, {1'b0, STANDBY});

    // R2: the window lengths the bench expects
    check(RD_EXP == 7 && WE_EXP == 6, "R2", {16'(RD_EXP), 16'(WE_EXP)}, {16'd7, 16'd6});

    for (int v = 0; v < NVEC; v++)
      access(VEC[v][26], VEC[v][25:24], VEC[v][23:16], VEC[v][15:0]);

    // R9/R7: a write held pending through a read; it is taken in the data-return cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_mask = 2'b11; req_addr = full_addr(8'h30);
    @(negedge clk);
    req_write = 1'b1; req_mask = 2'b11; req_addr = full_addr(8'h31); req_wdata = 16'hC3E1;
    for (int i = 1; i <= RD_EXP; i++) begin
      check(!req_ready && mem_addr == full_addr(8'h30), "R9", {req_ready, mem_addr}, {1'b0, full_addr(8'h30)});
      @(negedge clk);
    end
    check(rd_valid && req_ready, "R4 R9", {rd_valid, req_ready}, 2'b11);
    check(rd_data == shadow[8'h30], "R4", rd_data, shadow[8'h30]);
    @(negedge clk);
    req_valid = 1'b0;
    check(pins() == busy_pins(1'b1, 1'b1, 2'b11, 1'b0) && mem_addr == full_addr(8'h31),
          "R7 turnaround", pins(), busy_pins(1'b1, 1'b1, 2'b11, 1'b0));
    check(!rd_valid, "R10", rd_valid, 0);
    repeat (WE_EXP + 2) @(negedge clk);
    check(pins() == STANDBY, "R1", pins(), STANDBY);
    shadow[8'h31] = 16'hC3E1;
    access(1'b0, 2'b11, 8'h31, 16'h0000);

    // R8: masked lane keeps old byte, checked by a full read
    access(1'b1, 2'b10, 8'h42, 16'h77AA);
    access(1'b0, 2'b11, 8'h42, 16'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule